// File: doc/BRIEF.md
# Instruction Fetch Access Checker

This block decides whether an instruction fetch may proceed on a page. It takes three inputs:

- the second doubleword of the page table entry;
- a 64-bit instruction authority mask register;
- the one-bit verdict of the upstream key/pp protection logic.

It returns a single deny flag and a 64-bit status image. The status image is the set of bits to merge into the interrupt save/restore register when an instruction storage fault is raised.

The checks run in a fixed order, and the first failing check alone is reported:

1. Execution prevention, which looks at the no-execute and guarded bits of the entry.
2. The virtual page class key check. A 5-bit class key is assembled from two split fields of the entry. The key selects one of 32 two-bit masks in the authority register.
3. The key/pp protection verdict supplied from outside.

The decision logic is combinational. A parameter places an output register after it, and that register is on by default. All bit positions in this brief use big-endian numbering: bit 0 is the most significant bit of a 64-bit word, and bit 63 is the least significant.

Top module: `ifc_fetch_check`

## Requirements
- R1: While rst_ni is low, deny_o is 0 and status_o is all zeros.
- R2: If the no-execute bit of the entry (bit 61 of pte_dw1_i) is set, the fetch is denied. status_o then holds only bit 35 (value 0x10000000).
- R3: If the guarded bit of the entry (bit 60 of pte_dw1_i) is set, the result is the same as in R2: the fetch is denied with only bit 35 set.
- R4: The class key is {bit 2, bit 3, bit 52, bit 53, bit 54} of pte_dw1_i, most significant first. Key k selects the 2-bit mask held at bits 2k (mask bit 1) and 2k+1 (mask bit 0) of fetch_mask_i. For example, key 0b01010 selects bits 20:21.
- R5: If bit 0 of the selected mask is 1, the fetch is denied. status_o then holds only bit 42 (value 0x200000).
- R6: Bit 1 of the selected mask has no effect on a fetch. The same applies to the masks of all other keys.
- R7: If pp_deny_i is 1, the fetch is denied with only bit 36 set (value 0x08000000). This applies only when the checks of R2/R3 and R5 pass.
- R8: The priority order is execution prevention, then class key, then pp. A lower-priority status bit never appears alongside a higher-priority one.
- R9: When no check fails, deny_o is 0 and status_o is all zeros. deny_o is 1 exactly when status_o is nonzero.
- R10: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge. They do not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pte_dw1_i | input | 64 | Second doubleword of the page table entry |
| fetch_mask_i | input | 64 | Instruction authority mask register, 32 two-bit masks |
| pp_deny_i | input | 1 | Key/pp protection verdict, 1 = denied |
| deny_o | output | 1 | Fetch denied |
| status_o | output | 64 | Save/restore status image for the fault |

## Verification
The bench sweeps all 32 keys. In each case the lone denying mask bit is either present, or absent while every other key's deny bit is set. A key assembled in the wrong field order, or a mask indexed from the wrong end, would deny the wrong page.

The bench sets only the upper bit of the selected mask. A design that tested the wrong half of the mask would then fault on a legal fetch.

The bench raises all three causes together, and two at a time. A design with a broken priority would report the key or pp bit instead of the execution-prevention bit, or would OR several bits together.

Samples taken just before and just after the clock edge catch an output register that is missing or doubled.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int DW     = 64;
  localparam int MASK_W = 2;

  typedef enum logic [1:0] {
    VERDICT_ALLOW,
    VERDICT_EXEC,
    VERDICT_KEY,
    VERDICT_PROT
  } verdict_e;

  // big-endian bit number -> vector index
  function automatic int be2idx(input int be_pos);
    return DW - 1 - be_pos;
  endfunction
endpackage

// File: rtl/ifc_key_extract.sv
module ifc_key_extract
  import ifc_pkg::*;
#(
  parameter int HI_POS = 2,
  parameter int HI_W   = 2,
  parameter int LO_POS = 52,
  parameter int LO_W   = 3,
  localparam int KEY_W = HI_W + LO_W
) (
  input  logic [DW-1:0]    dw_i,
  output logic [KEY_W-1:0] key_o
);
  for (genvar i = 0; i < HI_W; i++) begin : g_hi
    assign key_o[KEY_W-1-i] = dw_i[be2idx(HI_POS + i)];
  end
  for (genvar j = 0; j < LO_W; j++) begin : g_lo
    assign key_o[LO_W-1-j] = dw_i[be2idx(LO_POS + j)];
  end

  logic unused_dw;
  assign unused_dw = ^dw_i;
endmodule

// File: rtl/ifc_mask_select.sv
module ifc_mask_select
  import ifc_pkg::*;
#(
  parameter int KEY_W = 5,
  localparam int NUM_KEYS = 1 << KEY_W
) (
  input  logic [DW-1:0]    mask_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             fetch_blk_o
);
  // low mask bit per key; the high mask bit is a data-side control
  logic [NUM_KEYS-1:0] fetch_bit;
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    assign fetch_bit[k] = mask_i[be2idx(MASK_W * k + MASK_W - 1)];
  end

  assign fetch_blk_o = fetch_bit[key_i];

  logic unused_mask;
  assign unused_mask = ^mask_i;
endmodule

// File: rtl/ifc_verdict.sv
module ifc_verdict
  import ifc_pkg::*;
#(
  parameter int EXEC_POS = 35,
  parameter int KEY_POS  = 42,
  parameter int PROT_POS = 36
) (
  input  logic          exec_blk_i,
  input  logic          key_blk_i,
  input  logic          prot_blk_i,
  output verdict_e      verdict_o,
  output logic          deny_o,
  output logic [DW-1:0] status_o
);
  always_comb begin
    if (exec_blk_i)      verdict_o = VERDICT_EXEC;
    else if (key_blk_i)  verdict_o = VERDICT_KEY;
    else if (prot_blk_i) verdict_o = VERDICT_PROT;
    else                 verdict_o = VERDICT_ALLOW;
  end

  always_comb begin
    status_o = '0;
    unique case (verdict_o)
      VERDICT_EXEC:  status_o[be2idx(EXEC_POS)] = 1'b1;
      VERDICT_KEY:   status_o[be2idx(KEY_POS)]  = 1'b1;
      VERDICT_PROT:  status_o[be2idx(PROT_POS)] = 1'b1;
      default:       status_o = '0;
    endcase
  end

  assign deny_o = (verdict_o != VERDICT_ALLOW);
endmodule

// File: rtl/ifc_fetch_check.sv
module ifc_fetch_check
  import ifc_pkg::*;
#(
  parameter bit REG_OUT  = 1'b1,
  parameter int NX_POS   = 61,
  parameter int G_POS    = 60,
  parameter int HI_POS   = 2,
  parameter int HI_W     = 2,
  parameter int LO_POS   = 52,
  parameter int LO_W     = 3,
  parameter int EXEC_POS = 35,
  parameter int KEY_POS  = 42,
  parameter int PROT_POS = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [63:0]   pte_dw1_i,
  input  logic [63:0]   fetch_mask_i,
  input  logic          pp_deny_i,
  output logic          deny_o,
  output logic [63:0]   status_o
);
  localparam int KEY_W = HI_W + LO_W;

  logic [KEY_W-1:0] class_key;
  logic             exec_blk, key_blk;
  verdict_e         verdict;
  logic             deny_c;
  logic [DW-1:0]    status_c;

  assign exec_blk = pte_dw1_i[be2idx(NX_POS)] | pte_dw1_i[be2idx(G_POS)];

  ifc_key_extract #(
    .HI_POS(HI_POS), .HI_W(HI_W), .LO_POS(LO_POS), .LO_W(LO_W)
  ) u_key (
    .dw_i  (pte_dw1_i),
    .key_o (class_key)
  );

  ifc_mask_select #(.KEY_W(KEY_W)) u_mask (
    .mask_i      (fetch_mask_i),
    .key_i       (class_key),
    .fetch_blk_o (key_blk)
  );

  ifc_verdict #(
    .EXEC_POS(EXEC_POS), .KEY_POS(KEY_POS), .PROT_POS(PROT_POS)
  ) u_verdict (
    .exec_blk_i (exec_blk),
    .key_blk_i  (key_blk),
    .prot_blk_i (pp_deny_i),
    .verdict_o  (verdict),
    .deny_o     (deny_c),
    .status_o   (status_c)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        deny_o   <= 1'b0;
        status_o <= '0;
      end else begin
        deny_o   <= deny_c;
        status_o <= status_c;
      end
    end
  end else begin : g_comb
    assign deny_o   = deny_c;
    assign status_o = status_c;
  end

  logic unused_verdict;
  assign unused_verdict = ^verdict;
endmodule

// File: rtl/ifc_fetch_check_sva.sv
module ifc_fetch_check_sva
  import ifc_pkg::*;
#(
  parameter bit REG_OUT  = 1'b1,
  parameter int NX_POS   = 61,
  parameter int G_POS    = 60,
  parameter int HI_POS   = 2,
  parameter int HI_W     = 2,
  parameter int LO_POS   = 52,
  parameter int LO_W     = 3,
  parameter int EXEC_POS = 35,
  parameter int KEY_POS  = 42,
  parameter int PROT_POS = 36
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] pte_dw1_i,
  input logic [63:0] fetch_mask_i,
  input logic        pp_deny_i,
  input logic        deny_o,
  input logic [63:0] status_o
);
  localparam int KEY_W = HI_W + LO_W;
  localparam logic [DW-1:0] EXEC_VAL = DW'(1) << be2idx(EXEC_POS);
  localparam logic [DW-1:0] KEY_VAL  = DW'(1) << be2idx(KEY_POS);
  localparam logic [DW-1:0] PROT_VAL = DW'(1) << be2idx(PROT_POS);

  logic [DW-1:0]    ref_dw1, ref_mask;
  logic             ref_pp;
  logic [KEY_W-1:0] key_ck;
  logic             exec_hit, key_hit;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ref_dw1 <= '0; ref_mask <= '0; ref_pp <= 1'b0;
      end else begin
        ref_dw1 <= pte_dw1_i; ref_mask <= fetch_mask_i; ref_pp <= pp_deny_i;
      end
    end
  end else begin : g_nodly
    assign ref_dw1  = pte_dw1_i;
    assign ref_mask = fetch_mask_i;
    assign ref_pp   = pp_deny_i;
  end

  always_comb begin
    for (int i = 0; i < HI_W; i++) key_ck[KEY_W-1-i] = ref_dw1[be2idx(HI_POS + i)];
    for (int j = 0; j < LO_W; j++) key_ck[LO_W-1-j]  = ref_dw1[be2idx(LO_POS + j)];
  end

  assign exec_hit = ref_dw1[be2idx(NX_POS)] | ref_dw1[be2idx(G_POS)];
  assign key_hit  = ref_mask[be2idx(MASK_W * int'(key_ck) + MASK_W - 1)];

  always @(posedge clk_i) begin
    if (REG_OUT && !rst_ni) begin
      a_reset_clear_r1: assert (!deny_o && status_o == '0);
    end
  end

  p_exec_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_hit |-> (deny_o && status_o == EXEC_VAL));

  p_key_deny_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_hit && key_hit) |-> (deny_o && status_o == KEY_VAL));

  p_pp_deny_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_hit && !key_hit && ref_pp) |-> (deny_o && status_o == PROT_VAL));

  p_allow_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_hit && !key_hit && !ref_pp) |-> (!deny_o && status_o == '0));

  p_single_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(status_o));

  p_deny_matches_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o == (status_o != '0));

  logic unused_ref;
  assign unused_ref = ^{ref_dw1, ref_mask};
endmodule

bind ifc_fetch_check ifc_fetch_check_sva #(
  .REG_OUT(REG_OUT), .NX_POS(NX_POS), .G_POS(G_POS),
  .HI_POS(HI_POS), .HI_W(HI_W), .LO_POS(LO_POS), .LO_W(LO_W),
  .EXEC_POS(EXEC_POS), .KEY_POS(KEY_POS), .PROT_POS(PROT_POS)
) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pte_dw1_i    (pte_dw1_i),
  .fetch_mask_i (fetch_mask_i),
  .pp_deny_i    (pp_deny_i),
  .deny_o       (deny_o),
  .status_o     (status_o)
);

// File: tb/ifc_fetch_check_bench.sv
`timescale 1ns/1ps
module ifc_fetch_check_bench;
  localparam logic [63:0] ST_EXEC = 64'h0000_0000_1000_0000; // bit 35
  localparam logic [63:0] ST_KEY  = 64'h0000_0000_0020_0000; // bit 42
  localparam logic [63:0] ST_PROT = 64'h0000_0000_0800_0000; // bit 36

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] pte_dw1_i = '0;
  logic [63:0] fetch_mask_i = '0;
  logic        pp_deny_i = 1'b0;
  logic        deny_o;
  logic [63:0] status_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  ifc_fetch_check u_ifc_fetch_check (
    .clk_i(clk_i), .rst_ni(rst_ni), .pte_dw1_i(pte_dw1_i),
    .fetch_mask_i(fetch_mask_i), .pp_deny_i(pp_deny_i),
    .deny_o(deny_o), .status_o(status_o)
  );

  function automatic logic bebit(input logic [63:0] v, input int n);
    return v[63-n];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] dw1, input logic [63:0] m,
                                        input logic pp);
    logic [4:0] k;
    if (bebit(dw1, 61) || bebit(dw1, 60)) return ST_EXEC;
    k = {bebit(dw1, 2), bebit(dw1, 3), bebit(dw1, 52), bebit(dw1, 53), bebit(dw1, 54)};
    if (bebit(m, 2*int'(k) + 1)) return ST_KEY;
    if (pp) return ST_PROT;
    return '0;
  endfunction

  function automatic logic [63:0] dw_for_key(input logic [4:0] k);
    logic [63:0] d;
    d = 64'h00F0_0000_0000_F000;  // unrelated bits
    d[63-2]  = k[4];
    d[63-3]  = k[3];
    d[63-52] = k[2];
    d[63-53] = k[1];
    d[63-54] = k[0];
    return d;
  endfunction

  task automatic check(input string req, input logic [63:0] exp_st);
    checks++;
    if (status_o !== exp_st || deny_o !== (exp_st != '0)) begin
      errors++;
      $display("FAIL %s: deny=%0b status=%h expected deny=%0b status=%h",
               req, deny_o, status_o, (exp_st != '0), exp_st);
    end
  endtask

  task automatic apply(input logic [63:0] dw1, input logic [63:0] m, input logic pp,
                       input string req);
    @(negedge clk_i);
    pte_dw1_i = dw1; fetch_mask_i = m; pp_deny_i = pp;
    @(negedge clk_i);
    check(req, model(dw1, m, pp));
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    pte_dw1_i = 64'h2000_0000_0000_0000; fetch_mask_i = '1; pp_deny_i = 1'b1;
    @(negedge clk_i);
    check("R1 reset", '0);
    pte_dw1_i = '0; fetch_mask_i = '0; pp_deny_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_allow();
    apply('0, '0, 1'b0, "R9 all clear");
    apply(64'h00F0_0000_0000_F000, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R9 unrelated bits");
  endtask

  task automatic t_exec();
    logic [63:0] nx, g;
    nx = 64'h0000_0000_0000_0004;  // bit 61
    g  = 64'h0000_0000_0000_0008;  // bit 60
    apply(nx, '0, 1'b0, "R2 no-execute");
    apply(g,  '0, 1'b0, "R3 guarded");
    apply(nx | dw_for_key(5'd10), '1, 1'b1, "R8 exec over key and pp");
    apply(g | g, '0, 1'b1, "R8 exec over pp");
  endtask

  task automatic t_key_example();
    // key 0b01010 -> mask at bits 20:21 = 0b01
    apply(64'h1000_0000_0000_0400, 64'h0000_0400_0000_0000, 1'b0, "R5 key example");
    check("R5 key example status", ST_KEY);
    apply(64'h1000_0000_0000_0400, 64'h0000_0800_0000_0000, 1'b0, "R6 mask high bit");
    check("R6 mask high bit allows", '0);
    apply(64'h1000_0000_0000_0400, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R6 all high bits");
  endtask

  task automatic t_key_sweep();
    for (int k = 0; k < 32; k++) begin
      logic [63:0] one_bit;
      one_bit = 64'h1 << (62 - 2*k);
      apply(dw_for_key(5'(k)), one_bit, 1'b0, "R4 sweep own bit");
      apply(dw_for_key(5'(k)), 64'h5555_5555_5555_5555 & ~one_bit, 1'b0,
            "R4 sweep other bits");
    end
  endtask

  task automatic t_pp();
    apply('0, '0, 1'b1, "R7 pp deny");
    apply(dw_for_key(5'd31), 64'h0000_0000_0000_0001, 1'b1, "R8 key over pp");
    apply(dw_for_key(5'd31), 64'h0000_0000_0000_0002, 1'b1, "R7 pp with high mask bit");
  endtask

  task automatic t_latency();
    apply('0, '0, 1'b0, "R10 prior allow");
    @(negedge clk_i);
    pte_dw1_i = 64'h4;
    #1;
    check("R10 no change before edge", '0);
    @(posedge clk_i);
    #1;
    check("R10 change after edge", ST_EXEC);
    @(negedge clk_i);
    pte_dw1_i = '0;
    @(negedge clk_i);
    check("R9 clears after deny", '0);
  endtask

  initial begin
    t_reset();
    t_allow();
    t_exec();
    t_key_example();
    t_key_sweep();
    t_pp();
    t_latency();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule